// File: doc/BRIEF.md
# Bidirectional Port Direction and Readback Control

This block is the per-pin control slice for a 16-pin bidirectional port arranged as two 8-pin lanes. A register file above it supplies five vectors: direction, output level, release-to-high-impedance, input inversion and pull-up request. The block turns them into pad-side controls (drive enable, drive value, pull-up enable) and builds the value that software sees when it reads the pin-state registers, one byte per lane.

Pad inputs go through a two-flop synchroniser before they are used. For a pin set as an input, the readback is the synchronised level, inverted when that pin's inversion bit is set. For a pin set as an output, the readback is the stored output level, so a released (high-impedance) output still reads back its programmed level. The block has no registers of its own apart from the synchroniser. Its outputs are combinational functions of the configuration vectors and the synchronised pins.

Top module: `gpio_port_ctl`

## Requirements
- R1: A direction bit of 1 makes its pin an input and 0 makes it an output. While reset is asserted the pad drive enable reads all zero. The synchroniser is cleared by reset.
- R2: The pad drive enable bit of a pin is 1 only when its direction bit is 0 and its release bit is 0.
- R3: The pad drive value of each pin equals its output-level bit, whatever the direction and release bits are.
- R4: For an input pin, readback bit = synchronised pad level XOR inversion bit. The pad level reaches readback on the second rising clock edge after it is applied.
- R5: For an output pin, readback equals the output-level bit whatever the release bit and the pad level are. The inversion bit has no effect on an output pin.
- R6: The pull-up enable of a pin equals its pull-up request bit when the pin is an input, and is 0 when it is an output.
- R7: Lane mapping: readback lane 0 (`rd_lane0`) bit k is pin k, and lane 1 (`rd_lane1`) bit k is pin 8+k. The MSB of each lane is the highest pin of that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir | input | 16 | Direction per pin, 1 = input |
| cfg_lvl | input | 16 | Stored output level per pin |
| cfg_hiz | input | 16 | Release output to high impedance, 1 = released |
| cfg_inv | input | 16 | Invert input readback, 1 = invert |
| cfg_pull | input | 16 | Pull-up request per pin |
| pad_in | input | 16 | Raw pad levels (asynchronous) |
| pad_oe | output | 16 | Pad drive enable |
| pad_out | output | 16 | Pad drive value |
| pad_pu | output | 16 | Pad pull-up enable |
| rd_lane0 | output | 8 | Readback for pins 7..0 |
| rd_lane1 | output | 8 | Readback for pins 15..8 |

## Verification
The bench builds the block with its default values: two lanes of eight pins and two synchroniser stages. Sixteen pins are enough to show that both lanes map correctly and that every pin is handled independently. The table vectors mix input and output pins, released pins and inverted pins in every combination. Directed tests check the two-edge synchroniser latency and that reset clears the synchroniser.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned LANES      = 2;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned PINS       = LANES * LANE_W;
  localparam int unsigned SYNC_STAGE = 2;

  // Drive enable: output direction and not released.
  function automatic logic drive_en(input logic dir_in, input logic hiz);
    return (~dir_in) & (~hiz);
  endfunction

  // Readback: inputs show the (optionally inverted) level, outputs show the stored level.
  function automatic logic readback(input logic dir_in, input logic lvl,
                                    input logic inv, input logic pin);
    return dir_in ? (pin ^ inv) : lvl;
  endfunction

  // Pull-up goes to the pad only for input pins.
  function automatic logic pull_en(input logic dir_in, input logic req);
    return dir_in & req;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_lane_ctl.sv
module gpio_lane_ctl
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] hiz,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] pull,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] oe,
  output logic [W-1:0] dout,
  output logic [W-1:0] pu,
  output logic [W-1:0] rd
);
  for (genvar k = 0; k < int'(W); k++) begin : g_pin
    assign oe[k]   = drive_en(dir_in[k], hiz[k]);
    assign dout[k] = lvl[k];
    assign pu[k]   = pull_en(dir_in[k], pull[k]);
    assign rd[k]   = readback(dir_in[k], lvl[k], inv[k], pin_sync[k]);
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PINS-1:0] cfg_dir,
  input  logic [PINS-1:0] cfg_lvl,
  input  logic [PINS-1:0] cfg_hiz,
  input  logic [PINS-1:0] cfg_inv,
  input  logic [PINS-1:0] cfg_pull,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_pu,
  output logic [LANE_W-1:0] rd_lane0,
  output logic [LANE_W-1:0] rd_lane1
);
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] rd_all;
  logic [PINS-1:0] oe_raw;

  gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_sync)
  );

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    gpio_lane_ctl #(.W(LANE_W)) u_lane (
      .dir_in  (cfg_dir [l*LANE_W +: LANE_W]),
      .lvl     (cfg_lvl [l*LANE_W +: LANE_W]),
      .hiz     (cfg_hiz [l*LANE_W +: LANE_W]),
      .inv     (cfg_inv [l*LANE_W +: LANE_W]),
      .pull    (cfg_pull[l*LANE_W +: LANE_W]),
      .pin_sync(pin_sync[l*LANE_W +: LANE_W]),
      .oe      (oe_raw  [l*LANE_W +: LANE_W]),
      .dout    (pad_out [l*LANE_W +: LANE_W]),
      .pu      (pad_pu  [l*LANE_W +: LANE_W]),
      .rd      (rd_all  [l*LANE_W +: LANE_W])
    );
  end

  // Drive is held off while reset is asserted.
  assign pad_oe   = rst_n ? oe_raw : '0;
  assign rd_lane0 = rd_all[LANE_W-1:0];
  assign rd_lane1 = rd_all[PINS-1:LANE_W];
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk
  import gpio_port_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] cfg_dir,
  input logic [PINS-1:0] cfg_lvl,
  input logic [PINS-1:0] cfg_hiz,
  input logic [PINS-1:0] cfg_pull,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_pu,
  input logic [LANE_W-1:0] rd_lane0,
  input logic [LANE_W-1:0] rd_lane1
);
  logic [PINS-1:0] rd_cat;
  assign rd_cat = {rd_lane1, rd_lane0};

  // R1
  always_comb begin
    if (!rst_n) reset_no_drive_chk: assert (pad_oe == '0);
  end

  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & (cfg_dir | cfg_hiz)) == '0);

  // R2
  oe_when_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe | cfg_dir | cfg_hiz) == '1);

  // R3
  out_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out == cfg_lvl);

  // R5
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_cat ^ cfg_lvl) & ~cfg_dir) == '0);

  // R6
  pull_out_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~cfg_dir) == '0);

  // R6
  pull_in_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu ^ cfg_pull) & cfg_dir) == '0);
endmodule

bind gpio_port_ctl gpio_port_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_lvl(cfg_lvl),
  .cfg_hiz(cfg_hiz), .cfg_pull(cfg_pull), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pu(pad_pu), .rd_lane0(rd_lane0), .rd_lane1(rd_lane1)
);

// File: tb/gpio_port_ctl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_dir, cfg_lvl, cfg_hiz, cfg_inv, cfg_pull, pad_in;
  logic [15:0] pad_oe, pad_out, pad_pu;
  logic [7:0]  rd_lane0, rd_lane1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_lvl(cfg_lvl),
    .cfg_hiz(cfg_hiz), .cfg_inv(cfg_inv), .cfg_pull(cfg_pull), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .rd_lane0(rd_lane0), .rd_lane1(rd_lane1)
  );

  // dir, lvl, hiz, inv, pull, pad
  typedef struct packed {
    logic [15:0] dir; logic [15:0] lvl; logic [15:0] hiz;
    logic [15:0] inv; logic [15:0] pull; logic [15:0] pad;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hA5C3},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0F0F, 16'hA5C3},
    '{16'h0000, 16'h1234, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'h0000, 16'hBEEF, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0000},
    '{16'h00FF, 16'h5A5A, 16'hF0F0, 16'h3C3C, 16'hFFFF, 16'h9669},
    '{16'hFF00, 16'hC0DE, 16'h0F0F, 16'hAAAA, 16'h5555, 16'h0180},
    '{16'hAAAA, 16'h6666, 16'hCCCC, 16'hF00F, 16'h1248, 16'h7E81},
    '{16'h8001, 16'h7FFE, 16'h4002, 16'h8001, 16'hFFFF, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cfg_dir = v.dir; cfg_lvl = v.lvl; cfg_hiz = v.hiz;
    cfg_inv = v.inv; cfg_pull = v.pull; pad_in = v.pad;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cfg_dir = '1; cfg_lvl = '0; cfg_hiz = '0; cfg_inv = '0; cfg_pull = '0;
    pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state: no drive, synchroniser cleared.
    cfg_dir = '0;
    #0.1;
    check("R1 oe in reset", pad_oe, 16'h0000);
    check("R1 sync cleared", {rd_lane1, rd_lane0}, 16'h0000 ^ 16'h0000 | 16'h0000);
    cfg_dir = '1;
    #0.1;
    check("R1 input readback cleared", {rd_lane1, rd_lane0}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[i]) begin
      vec_t v;
      logic [15:0] exp_rd;
      v = VECS[i];
      apply(v);
      exp_rd = 16'h0;
      for (int p = 0; p < 16; p++)
        exp_rd[p] = v.dir[p] ? (v.pad[p] ^ v.inv[p]) : v.lvl[p];
      check("R2 drive enable", pad_oe, ~v.dir & ~v.hiz);
      check("R3 drive value", pad_out, v.lvl);
      check("R4/R5 readback", {rd_lane1, rd_lane0}, exp_rd);
      check("R6 pull-up", pad_pu, v.dir & v.pull);
    end

    // R7: lane mapping with a single pin per lane.
    apply('{16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8001});
    check("R7 lane0 bit0 is pin0", {8'h0, rd_lane0}, 16'h0001);
    check("R7 lane1 msb is pin15", {8'h0, rd_lane1}, 16'h0080);

    // R4: two-edge synchroniser latency.
    @(negedge clk); pad_in = 16'h0100;
    @(negedge clk);
    check("R4 not after one edge", {rd_lane1, rd_lane0}, 16'h8001);
    @(negedge clk);
    check("R4 after two edges", {rd_lane1, rd_lane0}, 16'h0100);

    // R5: released output keeps stored level, pad and inversion ignored.
    apply('{16'h0000, 16'h00F0, 16'hFFFF, 16'hFFFF, 16'h0, 16'hFFFF});
    check("R5 released output readback", {rd_lane1, rd_lane0}, 16'h00F0);
    check("R2 released output not driven", pad_oe, 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule